// File: doc/BRIEF.md
# Asynchronous Request/Answer Handshake Controller

This block carries out one transfer between a master and a slave using only two wires: a request driven by the master and an answer driven by the slave. No transfer clock is shared. Each side runs on its own local clock and passes the other side's wire through a two-flop synchronizer before acting on it. The length of a transfer therefore stretches to suit whichever party is slower.

A two-bit mode input chooses how each side releases its wire. In **unlocked** mode (0) both sides release after a programmed number of their own cycles. In **half-locked** mode (1) the master holds request until it sees answer, while the slave still releases answer on a timer. In **full-locked** mode (2, and also 3) the master holds request until it sees answer, and the slave holds answer until it sees request fall. The master starts on a one-cycle `start` pulse and reports the end of the transfer with a one-cycle `done` pulse. The mode and the three timing settings are static configuration and change only while both sides are idle.

Master states: `M_IDLE` goes to `M_REQ` on start with answer low. `M_REQ` goes back to `M_IDLE` with done on its release condition in unlocked or half-locked mode, or to `M_DRAIN` in full-locked mode. `M_DRAIN` goes to `M_IDLE` with done once answer is seen low. Slave states: `S_IDLE` goes to `S_LAT` when request is seen. `S_LAT` goes to `S_ACK` after the latency count. `S_ACK` goes to `S_IDLE` on request low in full-locked mode, or to `S_REARM` when the hold count expires otherwise. `S_REARM` goes to `S_IDLE` once request is seen low.

Top module: `hs_link`

## Requirements
- R1: While either reset is held, `req`, `ack`, `busy` and `done` are all low.
- R2: A `start` pulse sampled while the master is idle and answer is seen low raises `req` at that same master clock edge.
- R3: In mode 0, `req` stays high for exactly `mst_hold`+1 master cycles whatever `ack` does, and `done` pulses in the cycle `req` falls.
- R4: In modes 1, 2 and 3, `req` falls only after `ack` has risen.
- R5: In mode 1, `done` pulses in the cycle `req` falls.
- R6: In modes 2 and 3, `ack` falls only after `req` has fallen, and `done` pulses only after `ack` has fallen.
- R7: In modes 0 and 1, `ack` stays high for exactly `slv_hold`+1 slave cycles whatever `req` does.
- R8: `ack` rises no sooner than `slv_lat`+2 slave cycles after `req` rises.
- R9: The slave raises `ack` exactly once for each request.
- R10: Mode value 3 behaves exactly like mode 2.
- R11: A `start` pulse while the master is busy is ignored: one transfer gives one `req` rise and one `done` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mst_clk | input | 1 | Master local clock |
| mst_rst_n | input | 1 | Master asynchronous reset, active low |
| slv_clk | input | 1 | Slave local clock |
| slv_rst_n | input | 1 | Slave asynchronous reset, active low |
| mode | input | 2 | Release discipline: 0 unlocked, 1 half-locked, 2 or 3 full-locked |
| mst_hold | input | CW | Master request hold count used in mode 0 |
| slv_hold | input | CW | Slave answer hold count used in modes 0 and 1 |
| slv_lat | input | CW | Slave response latency count |
| start | input | 1 | One-cycle pulse that begins a transfer (master clock) |
| req | output | 1 | Request wire, master to slave |
| ack | output | 1 | Answer wire, slave to master |
| busy | output | 1 | Master is in a transfer |
| done | output | 1 | One-cycle pulse at transfer completion (master clock) |

## Verification
The hardest situations to reach are the ones where the two timers disagree. In unlocked mode, request can fall while the slave is still counting its latency, so answer rises after request is already gone. In half-locked mode, answer can last only one slave cycle and must still reach the master through its synchronizer. The stimulus reaches these with directed runs at the extreme latency and hold values, on two clocks of unrelated period (4 ns and 6 ns). Seeded random runs then sweep every mode against random latencies and holds. For each transfer, edge timestamps taken at both clocks are compared to check the order of the request, answer and done edges.

// File: rtl/hs_pkg.sv
`timescale 1ns/1ps
package hs_pkg;

    typedef enum logic [1:0] {
        MODE_UNLOCKED = 2'd0,
        MODE_HALF     = 2'd1,
        MODE_FULL     = 2'd2,
        MODE_FULL_ALT = 2'd3
    } hs_mode_e;

    typedef enum logic [1:0] {
        M_IDLE  = 2'd0,
        M_REQ   = 2'd1,
        M_DRAIN = 2'd2
    } mst_state_e;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_LAT   = 2'd1,
        S_ACK   = 2'd2,
        S_REARM = 2'd3
    } slv_state_e;

    // master waits to see the answer before releasing request
    function automatic logic mst_gated(input logic [1:0] m);
        return (m != MODE_UNLOCKED);
    endfunction

    // slave waits to see request fall before releasing answer
    function automatic logic slv_gated(input logic [1:0] m);
        return m[1];
    endfunction

endpackage

// File: rtl/hs_sync.sv
`timescale 1ns/1ps
module hs_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/hs_master.sv
`timescale 1ns/1ps
module hs_master
    import hs_pkg::*;
#(
    parameter int CW    = 4,
    parameter int SYNCN = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    mode,
    input  logic [CW-1:0] hold,
    input  logic          start,
    input  logic          ack_in,
    output logic          req_o,
    output logic          busy,
    output logic          done
);
    mst_state_e    state, nxt;
    logic [CW-1:0] cnt;
    logic          ack_s;
    logic          fire_done;
    logic          release_ok;

    hs_sync #(.STAGES(SYNCN)) u_ack_sync (
        .clk(clk), .rst_n(rst_n), .d(ack_in), .q(ack_s)
    );

    assign release_ok = mst_gated(mode) ? ack_s : (cnt == hold);

    always_comb begin
        nxt       = state;
        fire_done = 1'b0;
        unique case (state)
            M_IDLE: begin
                if (start && !ack_s) nxt = M_REQ;
            end
            M_REQ: begin
                if (release_ok) begin
                    if (slv_gated(mode)) begin
                        nxt = M_DRAIN;
                    end else begin
                        nxt       = M_IDLE;
                        fire_done = 1'b1;
                    end
                end
            end
            M_DRAIN: begin
                if (!ack_s) begin
                    nxt       = M_IDLE;
                    fire_done = 1'b1;
                end
            end
            default: nxt = M_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= M_IDLE;
            cnt   <= '0;
        end else begin
            state <= nxt;
            if (nxt != state)       cnt <= '0;
            else if (state == M_REQ) cnt <= cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) done <= 1'b0;
        else        done <= fire_done;
    end

    assign req_o = (state == M_REQ);
    assign busy  = (state != M_IDLE);

    // R2
    req_rise_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req_o) |-> $past(!ack_s));
    // R4
    req_waits_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(req_o) && mode != MODE_UNLOCKED) |-> $past(ack_s));
    // R3
    req_timed_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(req_o) && mode == MODE_UNLOCKED) |-> ($past(cnt) == hold));
    // R6
    done_after_ack_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && mode[1]) |-> $past(!ack_s));
endmodule

// File: rtl/hs_slave.sv
`timescale 1ns/1ps
module hs_slave
    import hs_pkg::*;
#(
    parameter int CW    = 4,
    parameter int SYNCN = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    mode,
    input  logic [CW-1:0] hold,
    input  logic [CW-1:0] lat,
    input  logic          req_in,
    output logic          ack_o
);
    slv_state_e    state, nxt;
    logic [CW-1:0] cnt;
    logic          req_s;

    hs_sync #(.STAGES(SYNCN)) u_req_sync (
        .clk(clk), .rst_n(rst_n), .d(req_in), .q(req_s)
    );

    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE: begin
                if (req_s) nxt = S_LAT;
            end
            S_LAT: begin
                if (cnt == lat) nxt = S_ACK;
            end
            S_ACK: begin
                if (slv_gated(mode)) begin
                    if (!req_s) nxt = S_IDLE;
                end else if (cnt == hold) begin
                    nxt = S_REARM;
                end
            end
            S_REARM: begin
                if (!req_s) nxt = S_IDLE;
            end
            default: nxt = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= S_IDLE;
            cnt   <= '0;
        end else begin
            state <= nxt;
            if (nxt != state)                          cnt <= '0;
            else if (state == S_LAT || state == S_ACK) cnt <= cnt + 1'b1;
        end
    end

    assign ack_o = (state == S_ACK);

    // R6
    ack_waits_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ack_o) && mode[1]) |-> $past(!req_s));
    // R7
    ack_timed_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ack_o) && !mode[1]) |-> ($past(cnt) == hold));
    // R8
    ack_after_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack_o) |-> ($past(cnt) == lat));
endmodule

// File: rtl/hs_link.sv
`timescale 1ns/1ps
module hs_link #(
    parameter int CW    = 4,
    parameter int SYNCN = 2
) (
    input  logic          mst_clk,
    input  logic          mst_rst_n,
    input  logic          slv_clk,
    input  logic          slv_rst_n,
    input  logic [1:0]    mode,
    input  logic [CW-1:0] mst_hold,
    input  logic [CW-1:0] slv_hold,
    input  logic [CW-1:0] slv_lat,
    input  logic          start,
    output logic          req,
    output logic          ack,
    output logic          busy,
    output logic          done
);
    hs_master #(.CW(CW), .SYNCN(SYNCN)) u_mst (
        .clk(mst_clk), .rst_n(mst_rst_n), .mode(mode), .hold(mst_hold),
        .start(start), .ack_in(ack), .req_o(req), .busy(busy), .done(done)
    );

    hs_slave #(.CW(CW), .SYNCN(SYNCN)) u_slv (
        .clk(slv_clk), .rst_n(slv_rst_n), .mode(mode), .hold(slv_hold),
        .lat(slv_lat), .req_in(req), .ack_o(ack)
    );
endmodule

// File: tb/tb_hs_link.sv
`timescale 1ns/1ps
module tb_hs_link;
    localparam int CW = 4;
    localparam real SP = 6.0;

    logic mst_clk = 0, slv_clk = 0, mst_rst_n = 0, slv_rst_n = 0;
    logic [1:0] mode = 0;
    logic [CW-1:0] mst_hold = 0, slv_hold = 0, slv_lat = 0;
    logic start = 0;
    logic req, ack, busy, done;

    hs_link #(.CW(CW)) dut (
        .mst_clk(mst_clk), .mst_rst_n(mst_rst_n), .slv_clk(slv_clk), .slv_rst_n(slv_rst_n),
        .mode(mode), .mst_hold(mst_hold), .slv_hold(slv_hold), .slv_lat(slv_lat),
        .start(start), .req(req), .ack(ack), .busy(busy), .done(done)
    );

    always #2 mst_clk = ~mst_clk;
    always #3 slv_clk = ~slv_clk;

    int checks = 0, fails = 0;
    // master-side monitor state
    logic prev_req = 0;
    int req_rises = 0, req_len = 0, done_cnt = 0;
    realtime req_rise_t = 0, req_fall_t = 0, done_t = 0;
    logic done_at_fall = 0;
    always @(negedge mst_clk) begin
        if (req && !prev_req) begin req_rise_t = $realtime; req_rises++; req_len = 0; end
        if (req) req_len++;
        if (!req && prev_req) begin req_fall_t = $realtime; done_at_fall = done; end
        if (done) begin done_t = $realtime; done_cnt++; end
        prev_req = req;
    end
    // slave-side monitor state
    logic prev_ack = 0;
    int ack_rises = 0, ack_len = 0;
    realtime ack_rise_t = 0, ack_fall_t = 0;
    always @(negedge slv_clk) begin
        if (ack && !prev_ack) begin ack_rise_t = $realtime; ack_rises++; ack_len = 0; end
        if (ack) ack_len++;
        if (!ack && prev_ack) ack_fall_t = $realtime;
        prev_ack = ack;
    end

    int wd = 0;
    always @(posedge mst_clk) begin
        wd++;
        if (wd > 150000) begin
            $display("FAIL watchdog expired act=%0d exp<=150000", wd);
            $display("  TB_RESULT checks=%0d failures=%0d", checks + 1, fails + 1);
            $finish;
        end
    end

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    function automatic int exp_len(input int h); return h + 1; endfunction
    function automatic int min_ack_delay_ps(input int l); return $rtoi((l + 2) * SP * 1000.0); endfunction
    function automatic int ps(input realtime t); return $rtoi(t * 1000.0); endfunction

    task automatic run_xfer(input int m, input int hm, input int hs, input int lt, input bit extra);
        int b_rr, b_ar, b_dc, n;
        string mt;
        @(negedge mst_clk);
        mode = 2'(m); mst_hold = CW'(hm); slv_hold = CW'(hs); slv_lat = CW'(lt);
        repeat (3) @(negedge mst_clk);
        b_rr = req_rises; b_ar = ack_rises; b_dc = done_cnt;
        start = 1;
        @(negedge mst_clk);
        start = 0;
        // R2: req registered at the same edge that took start
        chk(req == 1'b1, "R2 req after start", int'(req), 1);
        if (extra) begin
            repeat (3) @(negedge mst_clk);
            start = 1; @(negedge mst_clk); start = 0;
        end
        n = 0;
        while (done_cnt == b_dc && n < 1000) begin @(negedge mst_clk); n++; end
        chk(n < 1000, "R11 done reached", n, 0);
        repeat (100) @(negedge mst_clk);
        mt = (m == 3) ? "R10" : "";
        chk(req_rises - b_rr == 1, {"R11 one req rise ", mt}, req_rises - b_rr, 1);
        chk(done_cnt - b_dc == 1, {"R11 one done ", mt}, done_cnt - b_dc, 1);
        chk(ack_rises - b_ar == 1, {"R9 one ack rise ", mt}, ack_rises - b_ar, 1);
        chk(ps(ack_rise_t - req_rise_t) >= min_ack_delay_ps(lt), {"R8 ack latency ", mt},
            ps(ack_rise_t - req_rise_t), min_ack_delay_ps(lt));
        if (m == 0) begin
            chk(req_len == exp_len(hm), "R3 req length", req_len, exp_len(hm));
            chk(done_at_fall, "R3 done with req fall", int'(done_at_fall), 1);
        end else begin
            chk(req_fall_t > ack_rise_t, {"R4 req falls after ack rise ", mt},
                ps(req_fall_t), ps(ack_rise_t));
        end
        if (m == 1) chk(done_at_fall, "R5 done with req fall", int'(done_at_fall), 1);
        if (m >= 2) begin
            chk(ack_fall_t > req_fall_t, {"R6 ack falls after req fall ", mt},
                ps(ack_fall_t), ps(req_fall_t));
            chk(done_t > ack_fall_t, {"R6 done after ack fall ", mt}, ps(done_t), ps(ack_fall_t));
        end else begin
            chk(ack_len == exp_len(hs), "R7 ack length", ack_len, exp_len(hs));
        end
    endtask

    initial begin
        void'($urandom(32'h5eed_0042));
        repeat (5) @(negedge mst_clk);
        // R1: everything low in reset
        chk(!req && !ack && !busy && !done, "R1 reset outputs", {req, ack, busy, done}, 0);
        mst_rst_n = 1; slv_rst_n = 1;
        repeat (4) @(negedge mst_clk);
        chk(!req && !ack && !busy && !done, "R1 after reset", {req, ack, busy, done}, 0);
        // directed corners
        run_xfer(0, 6, 3, 15, 0);   // request gone before answer
        run_xfer(0, 15, 0, 0, 0);   // answer falls while request still high
        run_xfer(1, 0, 0, 0, 0);    // one-cycle answer in half-locked mode
        run_xfer(1, 0, 15, 15, 0);
        run_xfer(2, 0, 0, 15, 0);
        run_xfer(3, 0, 7, 2, 0);    // R10 alias
        run_xfer(2, 0, 0, 3, 1);    // R11 start while busy
        // random sweep
        for (int i = 0; i < 40; i++) begin
            int m, hm;
            m  = int'($urandom_range(0, 3));
            hm = int'($urandom_range(6, 15));
            run_xfer(m, hm, int'($urandom_range(0, 15)), int'($urandom_range(0, 15)),
                     bit'($urandom_range(0, 1)));
        end
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule